// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block drives a 16-bit asynchronous NOR flash bus to carry out two host operations: programming one word, and erasing a run of sectors. The host places an opcode and its arguments on the request inputs and pulses `req`. The sequencer then issues the standard two-write unlock preamble and the operation's command words, one bus access per clock. It polls the device status bit until the device reports completion or a clock-cycle budget runs out, and puts the device back in read mode. Finally it raises `done` for one cycle with a result code on `status`.

Programming adds two checks around the command stream. Before any command is written, the target word is read, and the request is refused if the new data would need a 0 turned back into a 1. After the device returns to read mode, the word is read back and compared with the data. Erasing checks the requested sector range against a per-sector lock mask before touching the bus. It erases the sectors one after another, stops at the first timeout, and honours a host abort once the sector in progress has finished. Sector start addresses follow a bottom-boot layout: one 16 KiB boot sector, two 8 KiB parameter sectors, one 224 KiB sector, then uniform 256 KiB main sectors.

Top module: `nor_cmd_seq`

## Requirements
- R1: Program (`op`=0) writes 0x00AA to word 0x555, 0x0055 to word 0x2AA, 0x00A0 to word 0x555, then the data word to `prog_addr`, one write per clock; `fl_we` and `fl_re` are never high together.
- R2: Erase (`op`=1) writes, for each sector, 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30 to the sector's start word address, one write per clock.
- R3: Sector n starts at word address 0x0, 0x2000, 0x3000, 0x4000 for n = 0..3, and at 0x20000·(n−3) for n ≥ 4.
- R4: After the command writes, the target (sector start or program address) is read once per clock; erase is complete when read bit 7 is 1, program when read bit 7 equals data bit 7.
- R5: If POLL_LIMIT status reads pass without completion, the operation ends with `status` 4 (timeout), no verify read is made, and no further sector is erased.
- R6: Every polling phase is followed in the next cycle by a write of 0x00F0 to word 0x555.
- R7: Before programming, the target is read once; if (read & data) != data, the operation ends with `status` 3 and no write is issued.
- R8: After program completion and the read-mode write, the target is read once; `status` is 5 if it differs from the data, else 0.
- R9: An erase with `sec_first` > `sec_last`, or `sec_last` ≥ NSEC, ends with `status` 1; a valid range with any `sec_lock` bit set inside it ends with `status` 2; neither makes any bus access.
- R10: Sectors are erased in ascending order from `sec_first` to `sec_last`; an `abort` seen while busy stops the range after the current sector with `status` 6, unless that sector was the last one (`status` 0).
- R11: `req` is taken only while idle; `busy` is high from the cycle after `req` until the cycle `done` pulses; `done` lasts one cycle with `busy` low, and `status` holds its value until the next completion.
- R12: After reset `busy`, `done`, `fl_we` and `fl_re` are low and `status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start pulse, taken while idle |
| op | input | 1 | 0 = program one word, 1 = erase sector range |
| prog_addr | input | AW | Word address to program |
| prog_data | input | DW | Word to program |
| sec_first | input | SW | First sector of the erase range |
| sec_last | input | SW | Last sector of the erase range |
| abort | input | 1 | Ends an erase range after the current sector |
| sec_lock | input | NSEC | Per-sector erase lock mask |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | Result code of the last operation |
| fl_addr | output | AW | Flash word address |
| fl_wdata | output | DW | Flash write data |
| fl_we | output | 1 | Flash write strobe for this cycle |
| fl_re | output | 1 | Flash read strobe for this cycle |
| fl_rdata | input | DW | Flash read data, sampled at the end of a read cycle |

## Verification
Program requests are tried against an erased word, against a word whose zeros the new data would have to raise, and against a partial overwrite that only clears more bits. This separates the erased-check accept path from the reject path. A device that stores a wrong value tells the verify read apart from the status poll. A device that never finishes, and one that finishes exactly on the last allowed read, pin down the timeout boundary. Erase ranges are tried within the small boot sectors, across the boundary into the main sectors, on the final sector, with a locked sector, with invalid bounds, with an abort mid-range and with a timeout mid-range. Each behavioural device model answers polls with its own busy value, so the bench can tell the ready rule for erase apart from the ready rule for program.

// File: rtl/nor_cmd_seq_pkg.sv
`timescale 1ns/1ps
package nor_cmd_seq_pkg;

   localparam logic [7:0] CMD_UNLK_A    = 8'hAA;
   localparam logic [7:0] CMD_UNLK_B    = 8'h55;
   localparam logic [7:0] CMD_ERS_SETUP = 8'h80;
   localparam logic [7:0] CMD_ERS_GO    = 8'h30;
   localparam logic [7:0] CMD_PGM       = 8'hA0;
   localparam logic [7:0] CMD_READ_MODE = 8'hF0;

   localparam int unsigned UNLK_A_WADDR = 32'h555;
   localparam int unsigned UNLK_B_WADDR = 32'h2AA;

   localparam logic OP_PROGRAM = 1'b0;
   localparam logic OP_ERASE   = 1'b1;

   typedef enum logic [2:0] {
      ERR_NONE    = 3'd0,
      ERR_RANGE   = 3'd1,
      ERR_LOCKED  = 3'd2,
      ERR_DIRTY   = 3'd3,
      ERR_TIMEOUT = 3'd4,
      ERR_VERIFY  = 3'd5,
      ERR_ABORTED = 3'd6
   } seq_err_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK,
      ST_PREREAD,
      ST_CMD,
      ST_POLL,
      ST_EXIT,
      ST_VERIFY,
      ST_FIN
   } seq_state_e;

endpackage

// File: rtl/nor_cmd_seq_secmap.sv
`timescale 1ns/1ps
module nor_cmd_seq_secmap #(
   parameter int NSEC        = 11,
   parameter int AW          = 20,
   parameter int SW          = 4,
   parameter int BOOT_WORDS  = 32'h2000,
   parameter int PARAM_WORDS = 32'h1000,
   parameter int MAIN_WORDS  = 32'h20000
) (
   input  logic [SW-1:0]   sel,
   input  logic [SW-1:0]   first,
   input  logic [SW-1:0]   last,
   input  logic [NSEC-1:0] lock_mask,
   output logic [AW-1:0]   sel_base,
   output logic            range_bad,
   output logic            range_locked
);

   logic [AW-1:0]   base_tbl [NSEC];
   logic [NSEC-1:0] hit;

   for (genvar g = 0; g < NSEC; g++) begin : g_sec
      if (g == 0) begin : g_boot
         assign base_tbl[g] = '0;
      end else if (g <= 3) begin : g_param
         // the boot sector, then parameter sectors packed behind it
         assign base_tbl[g] = AW'(BOOT_WORDS + PARAM_WORDS * (g - 1));
      end else begin : g_main
         assign base_tbl[g] = AW'(MAIN_WORDS * (g - 3));
      end
      assign hit[g] = lock_mask[g] && (SW'(g) >= first) && (SW'(g) <= last);
   end

   assign sel_base     = (int'(sel) < NSEC) ? base_tbl[sel] : '0;
   assign range_bad    = (first > last) || (int'(last) >= NSEC);
   assign range_locked = |hit;

endmodule

// File: rtl/nor_cmd_seq_poll_timer.sv
`timescale 1ns/1ps
module nor_cmd_seq_poll_timer #(
   parameter int LIMIT = 65536,
   localparam int CW   = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic expired
);

   logic [CW-1:0] cnt_q;

   assign expired = (cnt_q == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (en && !expired)
         cnt_q <= cnt_q + 1'b1;
   end

   // R5
   tmo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(LIMIT - 1));

endmodule

// File: rtl/nor_cmd_seq_cmdrom.sv
`timescale 1ns/1ps
module nor_cmd_seq_cmdrom
   import nor_cmd_seq_pkg::*;
#(
   parameter int AW = 20,
   parameter int DW = 16
) (
   input  logic          op,
   input  logic [2:0]    step,
   input  logic [AW-1:0] sec_base,
   input  logic [AW-1:0] tgt,
   input  logic [DW-1:0] payload,
   output logic [AW-1:0] w_addr,
   output logic [DW-1:0] w_data,
   output logic          last_step,
   output logic          target_step
);

   localparam logic [AW-1:0] ADDR_A = AW'(UNLK_A_WADDR);
   localparam logic [AW-1:0] ADDR_B = AW'(UNLK_B_WADDR);

   always_comb begin
      w_addr      = ADDR_A;
      w_data      = DW'(CMD_UNLK_A);
      last_step   = 1'b0;
      target_step = 1'b0;
      if (op == OP_ERASE) begin
         case (step)
            3'd1, 3'd4: begin w_addr = ADDR_B; w_data = DW'(CMD_UNLK_B); end
            3'd2:       w_data = DW'(CMD_ERS_SETUP);
            3'd5: begin
               w_addr      = sec_base;
               w_data      = DW'(CMD_ERS_GO);
               last_step   = 1'b1;
               target_step = 1'b1;
            end
            default: ;
         endcase
      end else begin
         case (step)
            3'd1: begin w_addr = ADDR_B; w_data = DW'(CMD_UNLK_B); end
            3'd2: w_data = DW'(CMD_PGM);
            3'd3: begin
               w_addr      = tgt;
               w_data      = payload;
               last_step   = 1'b1;
               target_step = 1'b1;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/nor_cmd_seq.sv
`timescale 1ns/1ps
module nor_cmd_seq
   import nor_cmd_seq_pkg::*;
#(
   parameter int AW          = 20,
   parameter int DW          = 16,
   parameter int NSEC        = 11,
   parameter int POLL_LIMIT  = 65536,
   parameter int BOOT_WORDS  = 32'h2000,
   parameter int PARAM_WORDS = 32'h1000,
   parameter int MAIN_WORDS  = 32'h20000,
   localparam int SW         = $clog2(NSEC)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req,
   input  logic            op,
   input  logic [AW-1:0]   prog_addr,
   input  logic [DW-1:0]   prog_data,
   input  logic [SW-1:0]   sec_first,
   input  logic [SW-1:0]   sec_last,
   input  logic            abort,
   input  logic [NSEC-1:0] sec_lock,
   output logic            busy,
   output logic            done,
   output logic [2:0]      status,
   output logic [AW-1:0]   fl_addr,
   output logic [DW-1:0]   fl_wdata,
   output logic            fl_we,
   output logic            fl_re,
   input  logic [DW-1:0]   fl_rdata
);

   initial begin : param_chk
      assert (DW >= 8) else $fatal(1, "data width below status bit");
      assert (AW >= 11) else $fatal(1, "address too narrow for unlock words");
      assert (NSEC >= 5) else $fatal(1, "layout needs main sectors");
      assert (POLL_LIMIT >= 2) else $fatal(1, "poll budget too small");
      assert (longint'(MAIN_WORDS) * (NSEC - 3) <= (longint'(1) << AW))
         else $fatal(1, "sectors exceed address space");
   end

   seq_state_e    state_q;
   seq_err_e      status_q;
   logic          op_q;
   logic [AW-1:0] tgt_q;
   logic [DW-1:0] data_q;
   logic [SW-1:0] first_q, last_q, sec_q;
   logic [2:0]    step_q;
   logic          abort_q;
   logic          timed_out_q;

   logic [AW-1:0] sec_base;
   logic          range_bad, range_locked;
   logic [AW-1:0] rom_addr;
   logic [DW-1:0] rom_data;
   logic          rom_last, rom_target;
   logic          tmr_expired;
   logic [AW-1:0] poll_target;
   logic          ready;

   nor_cmd_seq_secmap #(
      .NSEC(NSEC), .AW(AW), .SW(SW),
      .BOOT_WORDS(BOOT_WORDS), .PARAM_WORDS(PARAM_WORDS), .MAIN_WORDS(MAIN_WORDS)
   ) u_map (
      .sel(sec_q), .first(first_q), .last(last_q), .lock_mask(sec_lock),
      .sel_base(sec_base), .range_bad(range_bad), .range_locked(range_locked)
   );

   nor_cmd_seq_cmdrom #(.AW(AW), .DW(DW)) u_rom (
      .op(op_q), .step(step_q), .sec_base(sec_base), .tgt(tgt_q), .payload(data_q),
      .w_addr(rom_addr), .w_data(rom_data), .last_step(rom_last), .target_step(rom_target)
   );

   nor_cmd_seq_poll_timer #(.LIMIT(POLL_LIMIT)) u_tmr (
      .clk(clk), .rst_n(rst_n),
      .clr(state_q == ST_CMD && rom_last),
      .en(state_q == ST_POLL),
      .expired(tmr_expired)
   );

   assign poll_target = (op_q == OP_ERASE) ? sec_base : tgt_q;
   assign ready = (op_q == OP_ERASE) ? fl_rdata[7] : (fl_rdata[7] == data_q[7]);

   always_comb begin
      fl_we    = 1'b0;
      fl_re    = 1'b0;
      fl_addr  = '0;
      fl_wdata = '0;
      case (state_q)
         ST_CMD: begin
            fl_we    = 1'b1;
            fl_addr  = rom_addr;
            fl_wdata = rom_data;
         end
         ST_EXIT: begin
            fl_we    = 1'b1;
            fl_addr  = AW'(UNLK_A_WADDR);
            fl_wdata = DW'(CMD_READ_MODE);
         end
         ST_PREREAD, ST_POLL, ST_VERIFY: begin
            fl_re   = 1'b1;
            fl_addr = poll_target;
         end
         default: ;
      endcase
   end

   assign busy   = (state_q != ST_IDLE) && (state_q != ST_FIN);
   assign done   = (state_q == ST_FIN);
   assign status = status_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         status_q    <= ERR_NONE;
         op_q        <= OP_PROGRAM;
         tgt_q       <= '0;
         data_q      <= '0;
         first_q     <= '0;
         last_q      <= '0;
         sec_q       <= '0;
         step_q      <= '0;
         abort_q     <= 1'b0;
         timed_out_q <= 1'b0;
      end else begin
         if (abort && state_q != ST_IDLE)
            abort_q <= 1'b1;
         case (state_q)
            ST_IDLE: if (req) begin
               op_q        <= op;
               tgt_q       <= prog_addr;
               data_q      <= prog_data;
               first_q     <= sec_first;
               last_q      <= sec_last;
               abort_q     <= 1'b0;
               timed_out_q <= 1'b0;
               state_q     <= ST_CHECK;
            end
            ST_CHECK: begin
               if (op_q == OP_ERASE) begin
                  if (range_bad) begin
                     status_q <= ERR_RANGE;
                     state_q  <= ST_FIN;
                  end else if (range_locked) begin
                     status_q <= ERR_LOCKED;
                     state_q  <= ST_FIN;
                  end else begin
                     sec_q   <= first_q;
                     step_q  <= '0;
                     state_q <= ST_CMD;
                  end
               end else begin
                  state_q <= ST_PREREAD;
               end
            end
            ST_PREREAD: begin
               if ((fl_rdata & data_q) != data_q) begin
                  status_q <= ERR_DIRTY;
                  state_q  <= ST_FIN;
               end else begin
                  step_q  <= '0;
                  state_q <= ST_CMD;
               end
            end
            ST_CMD: begin
               if (rom_last)
                  state_q <= ST_POLL;
               else
                  step_q <= step_q + 3'd1;
            end
            ST_POLL: begin
               if (ready) begin
                  state_q <= ST_EXIT;
               end else if (tmr_expired) begin
                  timed_out_q <= 1'b1;
                  state_q     <= ST_EXIT;
               end
            end
            ST_EXIT: begin
               if (timed_out_q) begin
                  status_q <= ERR_TIMEOUT;
                  state_q  <= ST_FIN;
               end else if (op_q == OP_PROGRAM) begin
                  state_q <= ST_VERIFY;
               end else if (sec_q == last_q) begin
                  status_q <= ERR_NONE;
                  state_q  <= ST_FIN;
               end else if (abort_q || abort) begin
                  status_q <= ERR_ABORTED;
                  state_q  <= ST_FIN;
               end else begin
                  sec_q   <= sec_q + 1'b1;
                  step_q  <= '0;
                  state_q <= ST_CMD;
               end
            end
            ST_VERIFY: begin
               status_q <= (fl_rdata == data_q) ? ERR_NONE : ERR_VERIFY;
               state_q  <= ST_FIN;
            end
            ST_FIN:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R1
   we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_we && fl_re));

   // R2
   unlock_b_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_we && !rom_target && fl_wdata == DW'(CMD_UNLK_B)) |-> fl_addr == AW'(UNLK_B_WADDR));

   // R6
   read_mode_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_re && state_q == ST_POLL) |=>
         (fl_re || (fl_we && fl_wdata == DW'(CMD_READ_MODE) && fl_addr == AW'(UNLK_A_WADDR))));

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R11
   quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!fl_we && !fl_re));

endmodule

// File: tb/nor_cmd_seq_test.sv
`timescale 1ns/1ps
module nor_cmd_seq_test;

   localparam int AW = 20;
   localparam int DW = 16;
   localparam int NSEC = 11;
   localparam int SW = 4;
   localparam int TMO = 16;

   localparam int K_IDLE = 0, K_WR = 1, K_RD = 2, K_END = 3;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic            rst_n, req, op, abort;
   logic [AW-1:0]   prog_addr;
   logic [DW-1:0]   prog_data;
   logic [SW-1:0]   sec_first, sec_last;
   logic [NSEC-1:0] sec_lock;
   logic            busy, done, fl_we, fl_re;
   logic [2:0]      status;
   logic [AW-1:0]   fl_addr;
   logic [DW-1:0]   fl_wdata;
   logic [DW-1:0]   fl_rdata = '0;

   nor_cmd_seq #(.POLL_LIMIT(TMO)) uut (
      .clk(clk), .rst_n(rst_n), .req(req), .op(op),
      .prog_addr(prog_addr), .prog_data(prog_data),
      .sec_first(sec_first), .sec_last(sec_last), .abort(abort), .sec_lock(sec_lock),
      .busy(busy), .done(done), .status(status),
      .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
      .fl_rdata(fl_rdata)
   );

   int n_run = 0, n_fail = 0;
   bit finished = 0;

   typedef struct { int k; int a; int d; } ent_t;
   ent_t exp_q[$];

   // behavioural flash: unwritten words read as erased
   logic [15:0] mem [int];
   int          busy_cnt = 0;
   logic [15:0] busy_val = '0;
   int          wcount = 0;
   int          delay_cfg = 0;
   bit          corrupt_cfg = 0;
   bit          erase_cfg = 0;

   function automatic int base_of(int n);
      if (n == 0) return 0;
      if (n == 1) return 'h2000;
      if (n == 2) return 'h3000;
      if (n == 3) return 'h4000;
      return 'h20000 * (n - 3);
   endfunction

   function automatic int end_of(int n);
      return (n == NSEC - 1) ? 'h100000 : base_of(n + 1);
   endfunction

   function automatic logic [15:0] peek(int a);
      return mem.exists(a) ? mem[a] : 16'hFFFF;
   endfunction

   task automatic wipe(int n);
      int ks[$];
      foreach (mem[k]) if (k >= base_of(n) && k < end_of(n)) ks.push_back(k);
      foreach (ks[i]) mem.delete(ks[i]);
   endtask

   always @(negedge clk) begin
      if (fl_re) begin
         fl_rdata = (busy_cnt > 0) ? busy_val : peek(int'(fl_addr));
         if (busy_cnt > 0) busy_cnt--;
      end
      if (fl_we) begin
         if (fl_wdata == 16'h00F0) begin
            wcount = 0;
            busy_cnt = 0;
         end else begin
            wcount++;
            if (!erase_cfg && wcount == 4) begin
               mem[int'(fl_addr)] = (peek(int'(fl_addr)) & fl_wdata) ^ (corrupt_cfg ? 16'h0001 : 16'h0000);
               busy_val = ~fl_wdata;
               busy_cnt = delay_cfg;
            end
            if (erase_cfg && wcount == 6) begin
               for (int n = 0; n < NSEC; n++) if (base_of(n) == int'(fl_addr)) wipe(n);
               busy_val = 16'h0000;
               busy_cnt = delay_cfg;
            end
         end
      end
   end

   task automatic check(bit ok, string rq, string what, int act, int expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
      end
   endtask

   task automatic push(int k, int a, int d);
      ent_t e;
      e.k = k; e.a = a; e.d = d;
      exp_q.push_back(e);
   endtask

   function automatic int polls(int dly);
      return (dly >= TMO) ? TMO : dly + 1;
   endfunction

   task automatic build_prog(int a, int d, int dly, bit bad, output int err);
      logic [15:0] pre;
      pre = peek(a);
      push(K_IDLE, 0, 0);
      push(K_RD, a, 0);
      if ((pre & 16'(d)) != 16'(d)) begin
         push(K_END, 0, 0);
         err = 3;
         return;
      end
      push(K_WR, 'h555, 'hAA);
      push(K_WR, 'h2AA, 'h55);
      push(K_WR, 'h555, 'hA0);
      push(K_WR, a, d);
      for (int i = 0; i < polls(dly); i++) push(K_RD, a, 0);
      push(K_WR, 'h555, 'hF0);
      if (dly >= TMO) begin
         err = 4;
      end else begin
         push(K_RD, a, 0);
         err = bad ? 5 : 0;
      end
      push(K_END, 0, 0);
   endtask

   task automatic build_erase(int f, int l, int dly, int abort_at, output int err);
      push(K_IDLE, 0, 0);
      if (f > l || l >= NSEC) begin
         push(K_END, 0, 0);
         err = 1;
         return;
      end
      for (int s = f; s <= l; s++) if (sec_lock[s]) begin
         push(K_END, 0, 0);
         err = 2;
         return;
      end
      err = 0;
      for (int s = f; s <= l; s++) begin
         push(K_WR, 'h555, 'hAA);
         push(K_WR, 'h2AA, 'h55);
         push(K_WR, 'h555, 'h80);
         push(K_WR, 'h555, 'hAA);
         push(K_WR, 'h2AA, 'h55);
         push(K_WR, base_of(s), 'h30);
         for (int i = 0; i < polls(dly); i++) push(K_RD, base_of(s), 0);
         push(K_WR, 'h555, 'hF0);
         if (dly >= TMO) begin err = 4; break; end
         if (s == l) break;
         if (abort_at >= 0) begin err = 6; break; end
      end
      push(K_END, 0, 0);
   endtask

   task automatic run(bit er, int a, int f, int l, int d, int dly, bit bad,
                      int abort_at, string rq_trace, string rq_err);
      int exp_err, mism, act_c, exp_c, ak;
      bit ok;
      exp_q.delete();
      if (er) build_erase(f, l, dly, abort_at, exp_err);
      else    build_prog(a, d, dly, bad, exp_err);
      @(negedge clk);
      op = er; prog_addr = AW'(a); prog_data = 16'(d);
      sec_first = SW'(f); sec_last = SW'(l);
      erase_cfg = er; delay_cfg = dly; corrupt_cfg = bad;
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      mism = 0; act_c = 0; exp_c = 0;
      foreach (exp_q[i]) begin
         abort = (i == abort_at);
         ak = fl_we ? K_WR : fl_re ? K_RD : done ? K_END : K_IDLE;
         ok = (ak == exp_q[i].k) && (busy == (exp_q[i].k != K_END)) && (done == (exp_q[i].k == K_END));
         if (exp_q[i].k == K_WR) ok = ok && int'(fl_addr) == exp_q[i].a && int'(fl_wdata) == exp_q[i].d;
         if (exp_q[i].k == K_RD) ok = ok && int'(fl_addr) == exp_q[i].a;
         if (!ok && mism == 0) begin
            act_c = (ak << 28) | (int'(fl_addr) << 8) | int'(fl_wdata[7:0]);
            exp_c = (exp_q[i].k << 28) | (exp_q[i].a << 8) | (exp_q[i].d & 'hFF);
         end
         if (!ok) mism++;
         if (exp_q[i].k != K_END) @(negedge clk);
      end
      abort = 1'b0;
      check(mism == 0, rq_trace, "bus trace", act_c, exp_c);
      check(int'(status) == exp_err, rq_err, "status", int'(status), exp_err);
      @(negedge clk);
      check(!done && !busy && int'(status) == exp_err, "R11", "done pulse/status hold",
            {done, busy, status}, exp_err);
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; req = 1'b0; op = 1'b0; abort = 1'b0;
      prog_addr = '0; prog_data = '0; sec_first = '0; sec_last = '0;
      sec_lock = 11'b000_0000_0010;
      repeat (3) @(negedge clk);
      check(!busy && !done && !fl_we && !fl_re && status == 3'd0, "R12", "reset state",
            {busy, done, fl_we, fl_re, status}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && !fl_we && !fl_re, "R12", "idle after reset",
            {busy, done, fl_we, fl_re}, 0);

      // program: erased word, then a word needing 0->1, then a bit-clearing overwrite
      run(0, 'h01234, 0, 0, 'h00FF, 3, 0, -1, "R1/R4/R6", "R8");
      run(0, 'h01234, 0, 0, 'h0F0F, 0, 0, -1, "R7", "R7");
      run(0, 'h01234, 0, 0, 'h000F, 0, 0, -1, "R1/R4", "R8");
      // stored value wrong -> verify error
      run(0, 'h05000, 0, 0, 'hA5A5, 2, 1, -1, "R8", "R8");
      // never ready -> timeout
      run(0, 'h06000, 0, 0, 'h1234, 40, 0, -1, "R5/R6", "R5");
      // ready on the very last allowed read
      run(0, 'h07000, 0, 0, 'h8000, TMO - 1, 0, -1, "R4/R5", "R5");
      // program a word in sector 2 to zero, then show it is not erased
      run(0, 'h03010, 0, 0, 'h0000, 1, 0, -1, "R1/R4", "R8");
      run(0, 'h03010, 0, 0, 'hFFFF, 0, 0, -1, "R7", "R7");
      // erase rejections
      run(1, 0, 0, 2, 0, 0, 0, -1, "R9", "R9");
      run(1, 0, 3, 2, 0, 0, 0, -1, "R9", "R9");
      run(1, 0, 9, 11, 0, 0, 0, -1, "R9", "R9");
      // range across parameter and main sectors
      run(1, 0, 2, 4, 0, 1, 0, -1, "R2/R3/R10", "R10");
      // the erased word now accepts all ones
      run(0, 'h03010, 0, 0, 'hFFFF, 2, 0, -1, "R2/R7", "R8");
      // final sector address
      run(1, 0, 10, 10, 0, 0, 0, -1, "R3/R2", "R10");
      // abort during the first sector of three
      run(1, 0, 5, 7, 0, 2, 0, 3, "R10", "R10");
      // timeout stops the range at its first sector
      run(1, 0, 8, 9, 0, 30, 0, -1, "R5", "R5");

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule